// File: doc/BRIEF.md
# Flash Erase Region Guard

This block decides which part of an on-chip flash array may be erased. Software writes a byte-wide select register in which each of the five low bits stands for one region of the array. An erase request carries a target address. The block answers in the same cycle whether that erase is allowed. Only the region whose select bit is set may be erased, and every other address is protected.

The flash space is split into regions of unequal size. Four 1 KB regions sit at the bottom of the space: region 0 is 0x0000–0x03FF, region 1 is 0x0400–0x07FF, region 2 is 0x0800–0x0BFF and region 3 is 0x0C00–0x0FFF. One 28 KB region, region 4, covers 0x1000–0x7FFF.

The select register is cleared in four cases:
- a synchronous power-on reset;
- the standby input;
- a low software write-enable input;
- any write that would leave more than one region selected.

A sticky fault flag records an error event reported by the program/erase machinery. While the flag is set, every erase request is denied. Only power-on reset or standby clears the flag.

Top module: `erase_region_guard`

## Requirements
- R1: After a power-on reset (`rst` high at a clock edge), the select read port `sel_rdata_o` and the status read port `stat_rdata_o` both read 0x00.
- R2: When `swe_i`=1 and `standby_i`=0, a write (`wr_en_i`=1) whose bits 4:0 hold at most one 1 stores bits 4:0 at the next clock edge. Bit n (n = 0..4) selects region n. `sel_rdata_o` bits 7:5 always read 0, whatever was written to them.
- R3: A write whose bits 4:0 contain two or more 1s clears all select bits to 0 at the next clock edge.
- R4: While `swe_i`=0, `sel_rdata_o` reads 0x00 in the same cycle. The stored selection is lost, so it still reads 0x00 after `swe_i` returns to 1.
- R5: While `standby_i`=1, `sel_rdata_o` reads 0x00. A clock edge with `standby_i`=1 clears both the selection and the fault flag.
- R6: `grant_o` is 1 only when the request address lies in the selected region. The region bounds are 0x0000–0x03FF, 0x0400–0x07FF, 0x0800–0x0BFF, 0x0C00–0x0FFF and 0x1000–0x7FFF for regions 0 to 4.
- R7: A request with an address of 0x8000 or above is always denied.
- R8: An `err_event_i` pulse sets the fault flag at the next clock edge. The flag reads as bit 7 of `stat_rdata_o`, and bits 6:0 of that port read 0. The flag stays set until reset or standby.
- R9: While the fault flag is set, `grant_o` is 0 for every address.
- R10: `grant_o` is combinational from the stored state, `req_valid_i` and `req_addr_i`. It is 0 whenever `req_valid_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| standby_i | input | 1 | Standby mode; clears the selection and the fault flag |
| swe_i | input | 1 | Software write-enable; the selection is held at 0 while low |
| wr_en_i | input | 1 | Write strobe for the select register |
| wdata_i | input | 8 | Write data for the select register |
| sel_rdata_o | output | 8 | Select register read value |
| stat_rdata_o | output | 8 | Status read value; fault flag in bit 7 |
| err_event_i | input | 1 | Program/erase error event |
| req_valid_i | input | 1 | Erase request valid |
| req_addr_i | input | 16 | Erase request target address |
| grant_o | output | 1 | Erase permitted for the current request |

## Verification
Two events can land in the same clock cycle: an error event, and a register write issued while an erase request is being answered. The bench raises `err_event_i`, a select write and a valid request all between the same two edges. It expects the grant in that cycle to follow the old selection with the flag still clear. After the edge, it expects both the new selection and the set flag to be visible, and the grant to be denied. A separate step pairs a standby pulse with an error event to confirm that the clear takes priority.

// File: rtl/erase_region_pkg.sv
package erase_region_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned N_SMALL   = 4;
  localparam int unsigned N_BLK     = N_SMALL + 1;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned SMALL_B   = 1024;
  localparam int unsigned TOP_END   = 32768;

  typedef logic [REG_W-1:0] reg_byte_t;
endpackage

// File: rtl/erase_sel_reg.sv
module erase_sel_reg #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned N_BLK = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             standby_i,
  input  logic             swe_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [N_BLK-1:0] sel_o
);
  logic [N_BLK-1:0] sel_q;
  logic [N_BLK-1:0] wr_bits;
  logic             wr_multi;
  logic             clr_now;
  logic             unused_hi;

  assign wr_bits   = wdata_i[N_BLK-1:0];
  assign unused_hi = ^wdata_i[REG_W-1:N_BLK];
  assign wr_multi  = ($countones(wr_bits) > 1);
  assign clr_now   = standby_i | ~swe_i;

  always_ff @(posedge clk) begin
    if (rst || clr_now) begin
      sel_q <= '0;
    end else if (wr_en_i) begin
      sel_q <= wr_multi ? '0 : wr_bits;
    end
  end

  // the clear conditions also mask the stored value immediately
  assign sel_o = clr_now ? '0 : sel_q;
endmodule

// File: rtl/erase_fault_flag.sv
module erase_fault_flag (
  input  logic clk,
  input  logic rst,
  input  logic standby_i,
  input  logic err_event_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst || standby_i) begin
      flag_q <= 1'b0;
    end else if (err_event_i) begin
      flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/erase_addr_decode.sv
module erase_addr_decode #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SMALL_B = 1024,
  parameter int unsigned N_SMALL = 4,
  parameter int unsigned TOP_END = 32768
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [N_SMALL:0]   hit_o
);
  localparam int unsigned            CW       = ADDR_W + 1;
  localparam logic [ADDR_W:0]        BIG_LO   = CW'(N_SMALL * SMALL_B);
  localparam logic [ADDR_W:0]        BIG_HI   = CW'(TOP_END);

  logic [ADDR_W:0] addr_x;
  assign addr_x = {1'b0, addr_i};

  for (genvar i = 0; i < N_SMALL; i++) begin : g_small
    localparam logic [ADDR_W:0] LO = CW'(i * SMALL_B);
    localparam logic [ADDR_W:0] HI = CW'((i + 1) * SMALL_B);
    assign hit_o[i] = (addr_x >= LO) && (addr_x < HI);
  end

  assign hit_o[N_SMALL] = (addr_x >= BIG_LO) && (addr_x < BIG_HI);
endmodule

// File: rtl/erase_region_guard.sv
module erase_region_guard
  import erase_region_pkg::*;
#(
  parameter int unsigned P_REG_W   = REG_W,
  parameter int unsigned P_ADDR_W  = ADDR_W,
  parameter int unsigned P_N_SMALL = N_SMALL,
  parameter int unsigned P_SMALL_B = SMALL_B,
  parameter int unsigned P_TOP_END = TOP_END
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                standby_i,
  input  logic                swe_i,
  input  logic                wr_en_i,
  input  logic [P_REG_W-1:0]  wdata_i,
  output logic [P_REG_W-1:0]  sel_rdata_o,
  output logic [P_REG_W-1:0]  stat_rdata_o,
  input  logic                err_event_i,
  input  logic                req_valid_i,
  input  logic [P_ADDR_W-1:0] req_addr_i,
  output logic                grant_o
);
  localparam int unsigned NB = P_N_SMALL + 1;

  logic [NB-1:0] sel;
  logic [NB-1:0] hit;
  logic          fault;

  erase_sel_reg #(.REG_W(P_REG_W), .N_BLK(NB)) sel_reg_i (
    .clk       (clk),
    .rst       (rst),
    .standby_i (standby_i),
    .swe_i     (swe_i),
    .wr_en_i   (wr_en_i),
    .wdata_i   (wdata_i),
    .sel_o     (sel)
  );

  erase_fault_flag fault_i (
    .clk         (clk),
    .rst         (rst),
    .standby_i   (standby_i),
    .err_event_i (err_event_i),
    .flag_o      (fault)
  );

  erase_addr_decode #(
    .ADDR_W (P_ADDR_W), .SMALL_B (P_SMALL_B),
    .N_SMALL(P_N_SMALL), .TOP_END (P_TOP_END)
  ) dec_i (
    .addr_i (req_addr_i),
    .hit_o  (hit)
  );

  assign sel_rdata_o  = {{(P_REG_W-NB){1'b0}}, sel};
  assign stat_rdata_o = {fault, {(P_REG_W-1){1'b0}}};
  assign grant_o      = req_valid_i & ~fault & (|(sel & hit));
endmodule

// File: rtl/erase_region_guard_chk.sv
module erase_region_guard_chk (
  input logic        clk,
  input logic        rst,
  input logic        standby_i,
  input logic        swe_i,
  input logic        wr_en_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  sel_rdata_o,
  input logic [7:0]  stat_rdata_o,
  input logic        err_event_i,
  input logic        req_valid_i,
  input logic [15:0] req_addr_i,
  input logic        grant_o
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_rdata_o)); // R3
  AST_MULTI_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && ($countones(wdata_i[4:0]) > 1)) |=> (sel_rdata_o == 8'h00)); // R3
  AST_SEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    sel_rdata_o[7:5] == 3'b000); // R2
  AST_SWE_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    !swe_i |-> (sel_rdata_o == 8'h00)); // R4
  AST_STBY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    standby_i |=> (stat_rdata_o == 8'h00)); // R5
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
    (err_event_i && !standby_i) |=> stat_rdata_o[7]); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (stat_rdata_o[7] && !standby_i) |=> stat_rdata_o[7]); // R8
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    stat_rdata_o[7] |-> !grant_o); // R9
  AST_HIGH_DENY: assert property (@(posedge clk) disable iff (rst)
    (req_addr_i >= 16'h8000) |-> !grant_o); // R7
  AST_NO_REQ_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |-> !grant_o); // R10
endmodule

bind erase_region_guard erase_region_guard_chk chk_i (
  .clk(clk), .rst(rst), .standby_i(standby_i), .swe_i(swe_i),
  .wr_en_i(wr_en_i), .wdata_i(wdata_i), .sel_rdata_o(sel_rdata_o),
  .stat_rdata_o(stat_rdata_o), .err_event_i(err_event_i),
  .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .grant_o(grant_o)
);

// File: tb/erase_region_guard_tb.sv
module erase_region_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        standby_i = 1'b0;
  logic        swe_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wdata_i = 8'h00;
  logic [7:0]  sel_rdata_o;
  logic [7:0]  stat_rdata_o;
  logic        err_event_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [15:0] req_addr_i = 16'h0000;
  logic        grant_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  erase_region_guard dut_i (
    .clk(clk), .rst(rst), .standby_i(standby_i), .swe_i(swe_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .sel_rdata_o(sel_rdata_o),
    .stat_rdata_o(stat_rdata_o), .err_event_i(err_event_i),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .grant_o(grant_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // region of an address per R6/R7, -1 when outside every region
  function automatic int region_of(logic [15:0] a);
    if (a < 16'h1000) return int'(a >> 10);
    if (a < 16'h8000) return 4;
    return -1;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_write(logic [7:0] d);
    step();
    wr_en_i = 1'b1; wdata_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic probe(string tag, logic [15:0] a, logic exp);
    req_addr_i = a; req_valid_i = 1'b1; #1;
    chk(tag, grant_o, exp);
    req_valid_i = 1'b0; #1;
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step(); rst = 1'b0; #1;
    chk("R1 sel after reset", sel_rdata_o, 8'h00);
    chk("R1 stat after reset", stat_rdata_o, 8'h00);
  endtask

  task automatic t_no_valid();
    do_write(8'h01);
    req_addr_i = 16'h0010; req_valid_i = 1'b0; #1;
    chk("R10 no valid no grant", grant_o, 1'b0);
    probe("R10 valid grant comb", 16'h0010, 1'b1);
  endtask

  task automatic t_single_and_decode();
    logic [15:0] pts [10] = '{16'h0000, 16'h03FF, 16'h0400, 16'h07FF, 16'h0800,
                              16'h0BFF, 16'h0C00, 16'h0FFF, 16'h1000, 16'h7FFF};
    for (int b = 0; b < 5; b++) begin
      do_write(8'hE0 | (8'h01 << b));
      chk("R2 single write readback", sel_rdata_o, 8'h01 << b);
      for (int k = 0; k < 10; k++)
        probe("R6 region decode", pts[k], region_of(pts[k]) == b);
    end
  endtask

  task automatic t_multi();
    do_write(8'h04);
    do_write(8'h03);
    chk("R3 two bits clear", sel_rdata_o, 8'h00);
    do_write(8'h08);
    do_write(8'h1F);
    chk("R3 all bits clear", sel_rdata_o, 8'h00);
    probe("R3 no grant after clear", 16'h0C00, 1'b0);
  endtask

  task automatic t_high_addr();
    do_write(8'h10);
    probe("R7 last region byte", 16'h7FFF, 1'b1);
    probe("R7 0x8000 denied", 16'h8000, 1'b0);
    probe("R7 0xFFFF denied", 16'hFFFF, 1'b0);
  endtask

  task automatic t_swe();
    do_write(8'h04);
    swe_i = 1'b0; #1;
    chk("R4 swe low reads zero", sel_rdata_o, 8'h00);
    step(); step();
    swe_i = 1'b1; #1;
    chk("R4 selection lost", sel_rdata_o, 8'h00);
    do_write(8'h00); // swe=0 write ignored check below
    swe_i = 1'b0;
    do_write(8'h02);
    swe_i = 1'b1; #1;
    chk("R4 write with swe low ignored", sel_rdata_o, 8'h00);
  endtask

  task automatic t_error();
    do_write(8'h01);
    probe("R9 grant before error", 16'h0100, 1'b1);
    step(); err_event_i = 1'b1; step(); err_event_i = 1'b0;
    chk("R8 flag set", stat_rdata_o, 8'h80);
    probe("R9 error blocks grant", 16'h0100, 1'b0);
    step(); step(); step();
    do_write(8'h02);
    chk("R8 flag sticky", stat_rdata_o, 8'h80);
    probe("R9 still blocked", 16'h0400, 1'b0);
  endtask

  task automatic t_standby();
    step(); standby_i = 1'b1; #1;
    chk("R5 standby reads zero", sel_rdata_o, 8'h00);
    err_event_i = 1'b1;
    step(); standby_i = 1'b0; err_event_i = 1'b0; #1;
    chk("R5 standby clears flag", stat_rdata_o, 8'h00);
    chk("R5 standby clears sel", sel_rdata_o, 8'h00);
  endtask

  task automatic t_same_cycle();
    do_write(8'h02);
    step();
    err_event_i = 1'b1; wr_en_i = 1'b1; wdata_i = 8'h08;
    req_addr_i = 16'h0400; req_valid_i = 1'b1; #1;
    chk("R10 grant from old state", grant_o, 1'b1);
    step();
    err_event_i = 1'b0; wr_en_i = 1'b0; req_valid_i = 1'b0;
    chk("R2 write beside error", sel_rdata_o, 8'h08);
    chk("R8 flag beside write", stat_rdata_o, 8'h80);
    probe("R9 new region blocked", 16'h0C00, 1'b0);
  endtask

  task automatic t_reset_clears_flag();
    rst = 1'b1; step(); rst = 1'b0; #1;
    chk("R1 reset clears flag", stat_rdata_o, 8'h00);
    chk("R1 reset clears sel", sel_rdata_o, 8'h00);
  endtask

  initial begin
    t_reset();
    t_no_valid();
    t_single_and_decode();
    t_multi();
    t_high_addr();
    t_swe();
    t_error();
    t_standby();
    t_same_cycle();
    t_reset_clears_flag();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG_LIMIT) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule